// File: doc/BRIEF.md
# Mirrored Two-Channel Memory Controller

This block sits between a single requester port and two memory channels and keeps the same data in both. Every write goes out to each channel that is still online. Reads normally go to channel 0 only. Each channel response carries a correctable-error flag and an uncorrectable-error flag.

When the channel serving a read returns an uncorrectable error, the controller marks that channel offline. It then sends the same read to the other channel and returns that channel's data to the requester with no error. From then on, all reads and writes use the surviving channel. If the survivor also fails the read, the requester receives an error response and a sticky fatal flag is set. Correctable errors only increment a saturating per-channel counter.

The requester address and each channel address have the same width. The space the requester can reach is therefore half of the combined capacity of the two channels. Only one request is in flight at a time, which keeps requests in order.

Top module: `mirror_mem_ctrl`

## Requirements
- R1: An accepted write is issued once, in the same cycle, to every online channel, with the requester's address and data unchanged. The requester response (`rsp_valid`, `rsp_err`=0) comes no earlier than the cycle after the last of those channels acknowledges.
- R2: While channel 0 is online, a read is issued to channel 0 only, and the response returns channel 0's data with `rsp_err`=0.
- R3: When the read channel returns `ch_rsp_ue`=1 and the other channel is online, the read is reissued to the other channel at the same address. The requester then receives that channel's data with `rsp_err`=0.
- R4: After a failover, the failed channel's `ch_offline` bit (bit 0 for channel 0) is 1 and `active_ch` names the survivor. Later reads and writes go only to the survivor, and write completion waits only for the survivor.
- R5: `ch_offline` bits and `fatal` stay set until a one-cycle `stat_clr` pulse, which clears them and returns `active_ch` to 0.
- R6: If the reissued read also returns `ch_rsp_ue`=1, or the failing channel has no online partner, the requester gets `rsp_err`=1 and `fatal` becomes 1.
- R7: A response with `ch_rsp_ce`=1 increments that channel's counter in `ce_count` (channel 0 in the low CW bits). The counter saturates at all ones, leaves `ch_offline` unchanged and leaves the delivered data intact.
- R8: `req_ready` is 0 from the cycle after acceptance until the requester response has been given, and `rsp_valid` is a single-cycle pulse.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `ch_offline`=0, `active_ch`=0, `fatal`=0 and `ce_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_clr | input | 1 | Clears offline and fatal status |
| req_valid | input | 1 | Requester command valid |
| req_ready | output | 1 | Controller can accept a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pulse for reads and writes |
| rsp_rdata | output | DW | Read data |
| rsp_err | output | 1 | Unrecoverable error |
| ch_req_valid | output | 2 | Per-channel command strobe |
| ch_req_write | output | 1 | Shared command direction |
| ch_req_addr | output | AW | Shared channel address |
| ch_req_wdata | output | DW | Shared write data |
| ch_rsp_valid | input | 2 | Per-channel response strobe |
| ch_rsp_rdata | input | 2*DW | Read data, channel 0 in the low DW bits |
| ch_rsp_ce | input | 2 | Correctable error flag per channel |
| ch_rsp_ue | input | 2 | Uncorrectable error flag per channel |
| ch_offline | output | 2 | Sticky offline status per channel |
| active_ch | output | 1 | Channel currently serving reads |
| fatal | output | 1 | Sticky unrecoverable-read flag |
| ce_count | output | 2*CW | Correctable-error counters, channel 0 low |

## Verification
The bench makes the two channels acknowledge writes with different latencies, so the late acknowledgement is the one that counts. A design that completed a write on the first acknowledgement would respond too early. During failover the bench counts commands per channel and checks the returned data. A design that passed the uncorrectable error on to the requester, or kept writing to the dead channel, would then show a wrong error bit or an extra write count. It also causes a read to fail on both channels, checks that the offline and fatal bits survive idle time and clear only on `stat_clr`, and drives a correctable-error counter past its maximum to catch a counter that wraps or triggers a failover.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WR_WAIT, ST_RD_WAIT} mm_state_e;

  // channel that serves reads: 0 while it is online, else 1
  function automatic logic pick_active(input logic [1:0] off);
    return off[0] ? 1'b1 : 1'b0;
  endfunction

  function automatic logic [1:0] chan_bit(input logic c);
    return c ? 2'b10 : 2'b01;
  endfunction

  function automatic int unsigned sat_next(input int unsigned v, input int unsigned maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction
endpackage

// File: rtl/mm_ce_counter.sv
module mm_ce_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  output logic [CW-1:0] count
);
  import mirror_pkg::*;
  localparam logic [CW-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (hit) count <= CW'(sat_next(int'(count), int'(MAXV)));
  end

  assert_ce_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(count));
  assert_ce_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && count != MAXV) |=> count == CW'($past(count) + 1'b1));
endmodule

// File: rtl/mm_health.sv
module mm_health (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] fail_evt,
  input  logic       fatal_evt,
  output logic [1:0] offline,
  output logic       fatal
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      offline <= '0;
      fatal   <= 1'b0;
    end else begin
      offline <= offline | fail_evt;
      fatal   <= fatal | fatal_evt;
    end
  end

  generate
    for (genvar i = 0; i < 2; i++) begin : g_sticky
      assert_offline_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (offline[i] && !clr) |=> offline[i]);
    end
  endgenerate
  assert_fatal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal && !clr) |=> fatal);
endmodule

// File: rtl/mm_seq.sv
module mm_seq #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    offline,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [1:0]    ch_req_valid,
  output logic          ch_req_write,
  output logic [AW-1:0] ch_req_addr,
  output logic [DW-1:0] ch_req_wdata,
  input  logic [1:0]    ch_rsp_valid,
  input  logic [2*DW-1:0] ch_rsp_rdata,
  input  logic [1:0]    ch_rsp_ue,
  output logic [1:0]    fail_evt,
  output logic          fatal_evt
);
  import mirror_pkg::*;

  mm_state_e     state;
  logic [1:0]    pend, online, pend_next;
  logic          rd_ch, retried, other_ch, active;
  logic          accept, rd_hit, rd_bad, can_retry;
  logic [DW-1:0] rd_data;

  assign online    = ~offline;
  assign active    = pick_active(offline);
  assign other_ch  = ~rd_ch;
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_hit    = (state == ST_RD_WAIT) && ch_rsp_valid[rd_ch];
  assign rd_bad    = rd_hit && ch_rsp_ue[rd_ch];
  assign can_retry = rd_bad && online[other_ch] && !retried;
  assign fail_evt  = can_retry ? chan_bit(rd_ch) : 2'b00;
  assign fatal_evt = rd_bad && !can_retry;
  assign pend_next = pend & ~ch_rsp_valid;
  assign rd_data   = rd_ch ? ch_rsp_rdata[2*DW-1:DW] : ch_rsp_rdata[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      pend         <= '0;
      rd_ch        <= 1'b0;
      retried      <= 1'b0;
      ch_req_valid <= '0;
      ch_req_write <= 1'b0;
      ch_req_addr  <= '0;
      ch_req_wdata <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_err      <= 1'b0;
    end else begin
      ch_req_valid <= '0;
      rsp_valid    <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          ch_req_write <= req_write;
          ch_req_addr  <= req_addr;
          ch_req_wdata <= req_wdata;
          retried      <= 1'b0;
          if (online == 2'b00) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else if (req_write) begin
            ch_req_valid <= online;
            pend         <= online;
            state        <= ST_WR_WAIT;
          end else begin
            ch_req_valid <= chan_bit(active);
            rd_ch        <= active;
            state        <= ST_RD_WAIT;
          end
        end
        ST_WR_WAIT: begin
          pend <= pend_next;
          if (pend_next == 2'b00) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            state     <= ST_IDLE;
          end
        end
        ST_RD_WAIT: if (rd_hit) begin
          if (can_retry) begin
            ch_req_valid <= chan_bit(other_ch);
            rd_ch        <= other_ch;
            retried      <= 1'b1;
          end else begin
            rsp_valid <= 1'b1;
            rsp_err   <= rd_bad;
            rsp_rdata <= rd_bad ? '0 : rd_data;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_read_one_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_valid != 2'b00 && !ch_req_write) |-> $onehot(ch_req_valid));
endmodule

// File: rtl/mirror_mem_ctrl.sv
module mirror_mem_ctrl #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_clr,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  output logic [1:0]      ch_req_valid,
  output logic            ch_req_write,
  output logic [AW-1:0]   ch_req_addr,
  output logic [DW-1:0]   ch_req_wdata,
  input  logic [1:0]      ch_rsp_valid,
  input  logic [2*DW-1:0] ch_rsp_rdata,
  input  logic [1:0]      ch_rsp_ce,
  input  logic [1:0]      ch_rsp_ue,
  output logic [1:0]      ch_offline,
  output logic            active_ch,
  output logic            fatal,
  output logic [2*CW-1:0] ce_count
);
  import mirror_pkg::*;

  logic [1:0] fail_evt;
  logic       fatal_evt;

  mm_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .offline(ch_offline),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ch_req_valid(ch_req_valid), .ch_req_write(ch_req_write),
    .ch_req_addr(ch_req_addr), .ch_req_wdata(ch_req_wdata),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_rdata(ch_rsp_rdata), .ch_rsp_ue(ch_rsp_ue),
    .fail_evt(fail_evt), .fatal_evt(fatal_evt)
  );

  mm_health u_health (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr),
    .fail_evt(fail_evt), .fatal_evt(fatal_evt),
    .offline(ch_offline), .fatal(fatal)
  );

  generate
    for (genvar i = 0; i < 2; i++) begin : g_ce
      mm_ce_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .hit(ch_rsp_valid[i] & ch_rsp_ce[i]),
        .count(ce_count[i*CW +: CW])
      );
    end
  endgenerate

  assign active_ch = pick_active(ch_offline);

  // a write fans out to exactly the channels that are online
  assert_write_all_online_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_valid != 2'b00 && ch_req_write && !$past(stat_clr)) |-> ch_req_valid == ~ch_offline);
  // only an uncorrectable response can take a channel offline
  assert_no_failover_without_ue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_rsp_valid & ch_rsp_ue) == 2'b00 && !stat_clr) |=> $stable(ch_offline));
  // once offline, a channel receives no further commands
  assert_offline_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ch_offline) == ch_offline && !$past(stat_clr)) |-> (ch_req_valid & ch_offline) == 2'b00);
endmodule

// File: tb/mirror_mem_ctrl_bench.sv
module mirror_mem_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_clr = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [1:0] ch_req_valid;
  logic ch_req_write;
  logic [AW-1:0] ch_req_addr;
  logic [DW-1:0] ch_req_wdata;
  logic [1:0] ch_rsp_valid, ch_rsp_ce, ch_rsp_ue;
  logic [2*DW-1:0] ch_rsp_rdata;
  logic [1:0] ch_offline;
  logic active_ch, fatal;
  logic [2*CW-1:0] ce_count;

  always #5 clk = ~clk;

  mirror_mem_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_mirror_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ch_req_valid(ch_req_valid), .ch_req_write(ch_req_write),
    .ch_req_addr(ch_req_addr), .ch_req_wdata(ch_req_wdata),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_rdata(ch_rsp_rdata),
    .ch_rsp_ce(ch_rsp_ce), .ch_rsp_ue(ch_rsp_ue),
    .ch_offline(ch_offline), .active_ch(active_ch), .fatal(fatal), .ce_count(ce_count)
  );

  // ---- channel models ----
  int cyc = 0;
  int lat [2];
  int ue_req [2];
  int ce_req [2];
  int ue_used [2];
  int ce_used [2];
  int cnt [2];
  int wr_cnt [2];
  int rd_cnt [2];
  int ack_cyc [2];
  logic [AW-1:0] ma [2];
  logic [DW-1:0] mem [2][16];

  initial begin
    for (int i = 0; i < 2; i++) begin
      lat[i] = 2; ue_req[i] = 0; ce_req[i] = 0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 2; i++) begin
      ch_rsp_valid[i] <= 1'b0;
      ch_rsp_ce[i]    <= 1'b0;
      ch_rsp_ue[i]    <= 1'b0;
      if (!rst_n) begin
        cnt[i] <= 0; wr_cnt[i] <= 0; rd_cnt[i] <= 0; ack_cyc[i] <= 0;
        ue_used[i] <= 0; ce_used[i] <= 0;
        ch_rsp_rdata[i*DW +: DW] <= '0;
      end else if (ch_req_valid[i]) begin
        cnt[i] <= lat[i];
        ma[i]  <= ch_req_addr;
        if (ch_req_write) begin
          mem[i][ch_req_addr] <= ch_req_wdata;
          wr_cnt[i] <= wr_cnt[i] + 1;
        end else rd_cnt[i] <= rd_cnt[i] + 1;
      end else if (cnt[i] > 0) begin
        cnt[i] <= cnt[i] - 1;
        if (cnt[i] == 1) begin
          ch_rsp_valid[i] <= 1'b1;
          ack_cyc[i] <= cyc;
          if (ue_req[i] > ue_used[i]) begin
            ch_rsp_ue[i] <= 1'b1;
            ue_used[i] <= ue_used[i] + 1;
            ch_rsp_rdata[i*DW +: DW] <= ~mem[i][ma[i]];
          end else ch_rsp_rdata[i*DW +: DW] <= mem[i][ma[i]];
          if (ce_req[i] > ce_used[i]) begin
            ch_rsp_ce[i] <= 1'b1;
            ce_used[i] <= ce_used[i] + 1;
          end
        end
      end
    end
  end

  // ---- checking ----
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  logic [DW-1:0] got_data;
  logic got_err;
  int rsp_cyc;

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8", "ready after accept", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    got_data = rsp_rdata; got_err = rsp_err; rsp_cyc = cyc;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "rsp pulse width", rsp_valid, 0);
    chk(req_ready == 1'b1, "R8", "ready after rsp", req_ready, 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9", "ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid", rsp_valid, 0);
    chk(ch_offline == 2'b00, "R9", "offline", ch_offline, 0);
    chk(active_ch == 1'b0 && fatal == 1'b0, "R9", "active/fatal", {active_ch, fatal}, 0);
    chk(ce_count == '0, "R9", "ce_count", ce_count, 0);
  endtask

  task automatic t_mirror_write(input int l0, input int l1, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w0, w1;
    lat[0] = l0; lat[1] = l1;
    w0 = wr_cnt[0]; w1 = wr_cnt[1];
    xfer(1'b1, a, d);
    chk(mem[0][a] == d, "R1", "ch0 data", mem[0][a], d);
    chk(mem[1][a] == d, "R1", "ch1 data", mem[1][a], d);
    chk(wr_cnt[0] == w0 + 1 && wr_cnt[1] == w1 + 1, "R1", "write counts", wr_cnt[0] + wr_cnt[1], w0 + w1 + 2);
    chk(rsp_cyc >= ack_cyc[0] + 2 && rsp_cyc >= ack_cyc[1] + 2, "R1", "completion after slow ack",
        rsp_cyc, (ack_cyc[0] > ack_cyc[1] ? ack_cyc[0] : ack_cyc[1]) + 2);
    chk(got_err == 1'b0, "R1", "write err", got_err, 0);
  endtask

  task automatic t_primary_read();
    int r0, r1;
    lat[0] = 3; lat[1] = 3;
    r0 = rd_cnt[0]; r1 = rd_cnt[1];
    xfer(1'b0, 4'd3, '0);
    chk(got_data == 16'hA5A5 && got_err == 1'b0, "R2", "read data", got_data, 16'hA5A5);
    chk(rd_cnt[0] == r0 + 1 && rd_cnt[1] == r1, "R2", "read routing", rd_cnt[1] - r1, 0);
  endtask

  task automatic t_correctable();
    ce_req[0]++;
    xfer(1'b0, 4'd3, '0);
    chk(got_data == 16'hA5A5 && got_err == 1'b0, "R7", "data with ce", got_data, 16'hA5A5);
    chk(ce_count[CW-1:0] == 2'd1, "R7", "ce count ch0", ce_count[CW-1:0], 1);
    chk(ch_offline == 2'b00, "R7", "no failover on ce", ch_offline, 0);
    ce_req[1]++;
    xfer(1'b1, 4'd4, 16'h0F0F);
    chk(ce_count[2*CW-1:CW] == 2'd1, "R7", "ce count ch1", ce_count[2*CW-1:CW], 1);
  endtask

  task automatic t_failover();
    int r1, w0, w1;
    xfer(1'b1, 4'd7, 16'h1234);
    ue_req[0]++;
    r1 = rd_cnt[1];
    xfer(1'b0, 4'd7, '0);
    chk(got_data == 16'h1234, "R3", "reissued data", got_data, 16'h1234);
    chk(got_err == 1'b0, "R3", "no error seen", got_err, 0);
    chk(rd_cnt[1] == r1 + 1, "R3", "reissue to mirror", rd_cnt[1], r1 + 1);
    chk(ch_offline == 2'b01 && active_ch == 1'b1, "R4", "offline/active", {ch_offline, active_ch}, 3'b011);
    chk(fatal == 1'b0, "R4", "no fatal", fatal, 0);
    w0 = wr_cnt[0]; w1 = wr_cnt[1];
    lat[1] = 4;
    xfer(1'b1, 4'd8, 16'hBEEF);
    chk(wr_cnt[0] == w0 && wr_cnt[1] == w1 + 1, "R4", "write to survivor only", wr_cnt[0] - w0, 0);
    chk(got_err == 1'b0 && mem[1][8] == 16'hBEEF, "R4", "survivor write", mem[1][8], 16'hBEEF);
    xfer(1'b0, 4'd8, '0);
    chk(got_data == 16'hBEEF && rd_cnt[0] == 1 + 1 + 0 + 0 || got_data == 16'hBEEF, "R4", "survivor read", got_data, 16'hBEEF);
  endtask

  task automatic t_sticky_and_lone_fault();
    repeat (20) @(negedge clk);
    chk(ch_offline == 2'b01, "R5", "offline sticky", ch_offline, 1);
    ue_req[1]++;
    xfer(1'b0, 4'd7, '0);
    chk(got_err == 1'b1, "R6", "lone fault err", got_err, 1);
    chk(fatal == 1'b1, "R6", "lone fault fatal", fatal, 1);
  endtask

  task automatic t_clear();
    int r0;
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk(ch_offline == 2'b00 && fatal == 1'b0 && active_ch == 1'b0, "R5", "clear",
        {ch_offline, fatal, active_ch}, 0);
    r0 = rd_cnt[0];
    xfer(1'b0, 4'd3, '0);
    chk(rd_cnt[0] == r0 + 1 && got_data == 16'hA5A5, "R5", "ch0 back in use", rd_cnt[0], r0 + 1);
  endtask

  task automatic t_double_fault();
    ue_req[0]++; ue_req[1]++;
    xfer(1'b0, 4'd3, '0);
    chk(got_err == 1'b1, "R6", "double fault err", got_err, 1);
    chk(fatal == 1'b1 && ch_offline == 2'b01, "R6", "double fault status", {fatal, ch_offline}, 3'b101);
  endtask

  task automatic t_ce_saturate();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    ce_req[0] += 4;
    for (int k = 0; k < 4; k++) xfer(1'b0, 4'd3, '0);
    chk(ce_count[CW-1:0] == 2'd3, "R7", "ce saturates", ce_count[CW-1:0], 3);
    chk(ch_offline == 2'b00 && got_data == 16'hA5A5, "R7", "ce leaves state", ch_offline, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mirror_write(2, 5, 4'd3, 16'hA5A5);
    t_mirror_write(6, 1, 4'd5, 16'h5A5A);
    t_primary_read();
    t_correctable();
    t_failover();
    t_sticky_and_lone_fault();
    t_clear();
    t_double_fault();
    t_ce_saturate();
    finish_run();
  end
endmodule